// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, word clock, serial data) and turns it into parallel left and right samples in the system clock domain. The bit clock and word clock are oversampled by the system clock through a synchroniser. Data is taken on each detected rising edge of the bit clock. A change of word clock level marks the boundary between the two channel slots.

A 3-bit format code selects one of eight framings: right-justified, left-justified or I2S, with 16, 20 or 24 bits per word. A polarity input chooses which word clock level carries the left channel. Every word arrives MSB first. It is placed left-aligned in a signed 24-bit field, so its sign bit is bit 23 whatever its length. A left word followed by a right word forms one stereo pair. When the right word is done, the pair appears on the outputs with a single-cycle valid strobe.

The format code and the polarity input are static while a stream runs. They are changed only around a reset.

Top module: `audio_serial_rx`

## Requirements
- R1: While rst_n is low, valid_o is 0 and left_o and right_o are 0.
- R2: Left-justified framing is selected by fmt_i codes 3'b011 (24-bit) and 3'b111 (20-bit). The word is the N bits sampled on consecutive bit-clock rising edges, starting with the first rising edge that samples the new word clock level.
- R3: I2S framing is selected by fmt_i codes 3'b100 (16-bit), 3'b110 (20-bit) and 3'b101 (24-bit). It is the same as left-justified framing, except that the MSB is sampled one bit-clock rising edge later.
- R4: Right-justified framing is selected by fmt_i codes 3'b000 (16-bit), 3'b001 (20-bit) and 3'b010 (24-bit). The word is the last N bits sampled before the rising edge that first samples a changed word clock level. That word belongs to the channel of the slot that is ending.
- R5: An N-bit word is output in bits [23:24-N] with its MSB at bit 23, and the lower 24-N bits are 0.
- R6: With ws_pol_i = 0 a high word clock marks the left slot. With ws_pol_i = 1 a low word clock marks the left slot.
- R7: valid_o pulses for one cycle per left-then-right pair, and left_o and right_o change only in that cycle. A right word with no left word captured since the last pair is discarded.
- R8: Bits sampled outside the word positions of a slot do not affect any output.
- R9: Suppose the bit clock rises before a system clock edge e0. If that bit-clock rise completes a right word, valid_o is high in the cycle after edge e0+3, which is four system clock edges in all. For left-justified and I2S framing, the completing rise is the one that samples the LSB. For right-justified framing, it is the rise that samples the changed word clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock; data taken on its rising edge |
| ws_i | input | 1 | Word clock selecting the channel slot |
| sd_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 3 | Framing and word length code |
| ws_pol_i | input | 1 | Word clock polarity: 0 = high is left, 1 = low is left |
| left_o | output | 24 | Left sample, signed, left-aligned |
| right_o | output | 24 | Right sample, signed, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a stereo pair is presented |

## Verification
A sample pair becomes visible four system-clock edges after the bit-clock rise that completes its right word. Two edges come from the synchroniser, one from the capture register and one from the pair register. The bench drives every input on the falling system-clock edge. It keeps the cycle number of the bit-clock rise that completes each right word and compares it with the cycle in which valid_o is seen. A monitor samples valid_o, left_o and right_o on falling edges and checks each pair against an ordered queue of expected words. Each group of pairs ends with a settle time longer than the latency, followed by a check that the number of pairs seen matches the number sent.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  localparam int MAX_WORD_W = 24;

  typedef enum logic [1:0] {
    FRM_RIGHT = 2'd0,
    FRM_LEFT  = 2'd1,
    FRM_I2S   = 2'd2
  } frame_e;

  typedef enum logic [1:0] {
    WL_16 = 2'd0,
    WL_20 = 2'd1,
    WL_24 = 2'd2
  } wlen_e;

endpackage

// File: rtl/asrx_in_sync.sv
module asrx_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_en,
  output logic ws_bit,
  output logic sd_bit
);

  localparam int LANES  = 3;
  localparam int L_SCK  = 2;
  localparam int L_WS   = 1;
  localparam int L_SD   = 0;

  logic [STAGES-1:0][LANES-1:0] stage_q, stage_d;
  logic                         sck_last_q, sck_last_d;

  always_comb begin
    stage_d[0] = {sck_i, ws_i, sd_i};
    for (int g = 1; g < STAGES; g++) begin
      stage_d[g] = stage_q[g-1];
    end
    sck_last_d = stage_q[STAGES-1][L_SCK];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= '0;
      sck_last_q <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      sck_last_q <= sck_last_d;
    end
  end

  assign bit_en = stage_q[STAGES-1][L_SCK] & ~sck_last_q;
  assign ws_bit = stage_q[STAGES-1][L_WS];
  assign sd_bit = stage_q[STAGES-1][L_SD];

endmodule

// File: rtl/asrx_fmt_decode.sv
module asrx_fmt_decode
  import asrx_pkg::*;
(
  input  logic [2:0] code,
  output frame_e     frame,
  output wlen_e      wlen
);

  always_comb begin
    unique case (code)
      3'b000: begin frame = FRM_RIGHT; wlen = WL_16; end
      3'b001: begin frame = FRM_RIGHT; wlen = WL_20; end
      3'b010: begin frame = FRM_RIGHT; wlen = WL_24; end
      3'b011: begin frame = FRM_LEFT;  wlen = WL_24; end
      3'b100: begin frame = FRM_I2S;   wlen = WL_16; end
      3'b101: begin frame = FRM_I2S;   wlen = WL_24; end
      3'b110: begin frame = FRM_I2S;   wlen = WL_20; end
      default: begin frame = FRM_LEFT; wlen = WL_20; end
    endcase
  end

endmodule

// File: rtl/asrx_word_capture.sv
module asrx_word_capture
  import asrx_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  ws_bit,
  input  logic                  sd_bit,
  input  logic                  ws_pol,
  input  frame_e                frame,
  input  wlen_e                 wlen,
  output logic                  word_vld,
  output logic                  word_left,
  output logic [MAX_WORD_W-1:0] word_data
);

  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

  // Bit history and slot tracking
  logic [MAX_WORD_W-1:0] hist_q, hist_d, hist_shift;
  logic                  ws_prev_q, ws_prev_d;
  logic                  primed_q, primed_d;
  logic [POS_W-1:0]      pos_q, pos_d, pos_now;

  // Extraction
  logic                  slot_edge;
  logic [POS_W-1:0]      len_bits, lead_bits, last_pos;
  logic                  take;
  logic                  take_left;
  logic [MAX_WORD_W-1:0] src;
  logic [MAX_WORD_W-1:0] aligned;

  // Output register
  logic                  vld_q, vld_d;
  logic                  left_q, left_d;
  logic [MAX_WORD_W-1:0] data_q, data_d;

  always_comb begin
    unique case (wlen)
      WL_16:   len_bits = POS_W'(16);
      WL_20:   len_bits = POS_W'(20);
      default: len_bits = POS_W'(24);
    endcase
    lead_bits = (frame == FRM_I2S) ? POS_ONE : '0;
    last_pos  = lead_bits + len_bits - POS_ONE;
  end

  always_comb begin
    slot_edge  = primed_q & (ws_bit != ws_prev_q);
    hist_shift = {hist_q[MAX_WORD_W-2:0], sd_bit};
    if (slot_edge) begin
      pos_now = '0;
    end else if (pos_q == POS_MAX) begin
      pos_now = POS_MAX;
    end else begin
      pos_now = pos_q + POS_ONE;
    end

    if (frame == FRM_RIGHT) begin
      take      = slot_edge;
      src       = hist_q;
      take_left = ws_prev_q ^ ws_pol;
    end else begin
      take      = (pos_now == last_pos);
      src       = hist_shift;
      take_left = ws_bit ^ ws_pol;
    end

    unique case (wlen)
      WL_16:   aligned = {src[15:0], 8'h00};
      WL_20:   aligned = {src[19:0], 4'h0};
      default: aligned = src;
    endcase
  end

  always_comb begin
    hist_d    = hist_shift;
    ws_prev_d = ws_bit;
    primed_d  = 1'b1;
    pos_d     = pos_now;
    vld_d     = bit_en & take;
    left_d    = take_left;
    data_d    = aligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      ws_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      pos_q     <= POS_MAX;
    end else if (bit_en) begin
      hist_q    <= hist_d;
      ws_prev_q <= ws_prev_d;
      primed_q  <= primed_d;
      pos_q     <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      left_q <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (vld_d) begin
        left_q <= left_d;
        data_q <= data_d;
      end
    end
  end

  assign word_vld  = vld_q;
  assign word_left = left_q;
  assign word_data = data_q;

endmodule

// File: rtl/asrx_pair.sv
module asrx_pair
  import asrx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_vld,
  input  logic                  word_left,
  input  logic [MAX_WORD_W-1:0] word_data,
  output logic [MAX_WORD_W-1:0] left_out,
  output logic [MAX_WORD_W-1:0] right_out,
  output logic                  pair_vld
);

  logic [MAX_WORD_W-1:0] hold_q, hold_d;
  logic                  have_q, have_d;
  logic [MAX_WORD_W-1:0] lout_q, lout_d, rout_q, rout_d;
  logic                  pv_q, pv_d;
  logic                  hold_en, out_en;

  always_comb begin
    hold_en = word_vld & word_left;
    out_en  = word_vld & ~word_left & have_q;
    hold_d  = word_data;
    if (hold_en) begin
      have_d = 1'b1;
    end else if (word_vld) begin
      have_d = 1'b0;
    end else begin
      have_d = have_q;
    end
    lout_d = hold_q;
    rout_d = word_data;
    pv_d   = out_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      have_q <= 1'b0;
      lout_q <= '0;
      rout_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      have_q <= have_d;
      pv_q   <= pv_d;
      if (hold_en) begin
        hold_q <= hold_d;
      end
      if (out_en) begin
        lout_q <= lout_d;
        rout_q <= rout_d;
      end
    end
  end

  assign left_out  = lout_q;
  assign right_out = rout_q;
  assign pair_vld  = pv_q;

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        ws_i,
  input  logic        sd_i,
  input  logic [2:0]  fmt_i,
  input  logic        ws_pol_i,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);

  logic                  bit_en, ws_bit, sd_bit;
  frame_e                frame;
  wlen_e                 wlen;
  logic                  word_vld, word_left;
  logic [MAX_WORD_W-1:0] word_data;

  asrx_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_i  (sck_i),
    .ws_i   (ws_i),
    .sd_i   (sd_i),
    .bit_en (bit_en),
    .ws_bit (ws_bit),
    .sd_bit (sd_bit)
  );

  asrx_fmt_decode u_dec (
    .code  (fmt_i),
    .frame (frame),
    .wlen  (wlen)
  );

  asrx_word_capture #(.POS_W(POS_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .ws_bit    (ws_bit),
    .sd_bit    (sd_bit),
    .ws_pol    (ws_pol_i),
    .frame     (frame),
    .wlen      (wlen),
    .word_vld  (word_vld),
    .word_left (word_left),
    .word_data (word_data)
  );

  asrx_pair u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (word_vld),
    .word_left (word_left),
    .word_data (word_data),
    .left_out  (left_o),
    .right_out (right_o),
    .pair_vld  (valid_o)
  );

endmodule

// File: rtl/asrx_rx_checker.sv
module asrx_rx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt_i,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        valid_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!valid_o && left_o == 24'd0 && right_o == 24'd0)
        else $error("outputs not idle in reset"); // R1
    end
  end

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7

  AST_PAD_16: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (fmt_i == 3'b000 || fmt_i == 3'b100))
      |-> (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00)); // R5

  AST_PAD_20: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (fmt_i == 3'b001 || fmt_i == 3'b110 || fmt_i == 3'b111))
      |-> (left_o[3:0] == 4'h0 && right_o[3:0] == 4'h0)); // R5

endmodule

bind audio_serial_rx asrx_rx_checker u_asrx_rx_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .fmt_i   (fmt_i),
  .left_o  (left_o),
  .right_o (right_o),
  .valid_o (valid_o)
);

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;

  localparam int LAT      = 4;
  localparam int HALF     = 4;
  localparam int SLOT     = 32;
  localparam int NPAIRS   = 4;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n, sck_i, ws_i, sd_i, ws_pol_i;
  logic [2:0]  fmt_i;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  always #2 clk = ~clk;

  audio_serial_rx u_audio_serial_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (sck_i),
    .ws_i     (ws_i),
    .sd_i     (sd_i),
    .fmt_i    (fmt_i),
    .ws_pol_i (ws_pol_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;
  logic [23:0] q_l[$];
  logic [23:0] q_r[$];
  string       grp_tag;
  int          pairs_seen;
  int unsigned last_rise;
  int unsigned t_done;
  bit          lat_pending;

  // 0 = right-justified, 1 = left-justified, 2 = I2S
  function automatic int fmt_kind(input logic [2:0] c);
    if (c == 3'b011 || c == 3'b111) return 1;
    if (c[2]) return 2;
    return 0;
  endfunction

  function automatic int fmt_len(input logic [2:0] c);
    case (c)
      3'b000, 3'b100: return 16;
      3'b001, 3'b110, 3'b111: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] w, input int n);
    logic [23:0] m;
    m = (24'h1 << n) - 24'h1;
    return (w & m) << (24 - n);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      if (q_l.size() == 0) begin
        check(1'b0, "R7", "unexpected valid", 24'h1, 24'h0);
      end else begin
        logic [23:0] el, er;
        el = q_l.pop_front();
        er = q_r.pop_front();
        pairs_seen++;
        check(left_o == el, grp_tag, "left word", left_o, el);
        check(right_o == er, grp_tag, "right word", right_o, er);
        if (lat_pending) begin
          check((cyc - t_done) == LAT, "R9", "latency",
                24'(cyc - t_done), 24'(LAT));
          lat_pending = 1'b0;
        end
      end
    end
  end

  task automatic send_bit(input logic ws, input logic d);
    sck_i = 1'b0;
    ws_i  = ws;
    sd_i  = d;
    repeat (HALF) @(negedge clk);
    sck_i = 1'b1;
    last_rise = cyc;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_slot(input bit is_left, input logic [23:0] w,
                           input int kind, input int n, input logic pol);
    logic lvl;
    lvl = is_left ? ~pol : pol;
    for (int p = 0; p < SLOT; p++) begin
      logic b;
      b = 1'($urandom & 1);
      if (kind == 1 && p < n) b = w[n-1-p];
      if (kind == 2 && p >= 1 && p <= n) b = w[n-p];
      if (kind == 0 && p >= SLOT - n) b = w[SLOT-1-p];
      send_bit(lvl, b);
      if ((kind != 0 && !is_left && p == n - 1 + (kind == 2 ? 1 : 0)) ||
          (kind == 0 && is_left && p == 0)) begin
        t_done      = last_rise;
        lat_pending = 1'b1;
      end
    end
  endtask

  task automatic run_group(input logic [2:0] code, input logic pol);
    int kind, n;
    kind = fmt_kind(code);
    n    = fmt_len(code);
    @(negedge clk);
    rst_n = 1'b0;
    sck_i = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
    fmt_i = code; ws_pol_i = pol;
    lat_pending = 1'b0;
    pairs_seen  = 0;
    q_l.delete();
    q_r.delete();
    repeat (3) @(negedge clk);
    check(!valid_o && left_o == 24'h0 && right_o == 24'h0, "R1",
          "reset state", left_o | right_o | {23'h0, valid_o}, 24'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    grp_tag = (kind == 1) ? "R2 R6 R8" : (kind == 2) ? "R3 R6 R8" : "R4 R6 R8";
    if (n < 24) grp_tag = {grp_tag, " R5"};
    send_slot(1'b0, 24'($urandom), kind, n, pol);
    for (int i = 0; i < NPAIRS; i++) begin
      logic [23:0] wl, wr;
      if (i == 0) begin
        wl = 24'h1 << (n - 1);
        wr = (24'h1 << (n - 1)) - 24'h1;
      end else if (i == 1) begin
        wl = 24'hFFFFFF;
        wr = 24'h000000;
      end else begin
        wl = 24'($urandom);
        wr = 24'($urandom);
      end
      q_l.push_back(expect_word(wl, n));
      q_r.push_back(expect_word(wr, n));
      send_slot(1'b1, wl, kind, n, pol);
      send_slot(1'b0, wr, kind, n, pol);
    end
    send_slot(1'b1, 24'($urandom), kind, n, pol);
    repeat (12) @(negedge clk);
    check(pairs_seen == NPAIRS, "R7", "pair count", 24'(pairs_seen), 24'(NPAIRS));
  endtask

  initial begin
    void'($urandom(32'h5EED_0716));
    rst_n = 1'b0; sck_i = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
    fmt_i = 3'b000; ws_pol_i = 1'b0;
    for (int c = 0; c < 8; c++) begin
      for (int pl = 0; pl < 2; pl++) begin
        run_group(3'(c), 1'(pl));
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule